// File: doc/BRIEF.md
# Pulse-Position Header Routing Lookup

This block is the header processor of a packet node. Each packet starts with a start-of-packet marker followed by an N-bit destination address, sent one bit per valid cycle with the least significant bit first. The block turns the address into a pulse-position frame of 2^N slots with a single pulse at the slot whose index equals the address. It then walks that frame slot by slot and ANDs it against every routing entry.

There is one routing entry per output port. Each entry is a 2^N-bit mask with a bit set for every address that should leave through that port. An entry matches when the frame pulse lands on one of its set bits. Every matching port has its enable raised for the programmed payload length, so a packet can be unicast or multicast. A packet that matches no entry is dropped and flagged.

Entries are loaded through a simple write port, one whole mask per write. A write that arrives while a packet is being handled is parked and applied once the engine is idle again, so a lookup always sees a consistent table.

Top module: `ppm_route_top`

## Requirements
- R1: After reset `port_en` and `no_match` are 0 and every table entry is empty, so a packet sent before any write is reported as unmatched.
- R2: After `sop` is sampled in the idle state, the next N cycles with `din_valid` high deliver the address. The first of these bits is address bit 0.
- R3: Writing `wr_mask` to entry `wr_port` routes address k to port `wr_port` when `wr_mask[k]` is 1. For a packet with address A, bit p of `port_en` is 1 exactly when bit A of entry p is 1.
- R4: An address whose bit is set in several entries raises all of those port enables in the same cycle (multicast).
- R5: With the address bits on consecutive cycles, `port_en` rises on the (N + 2^N + 1)-th rising edge after the edge that samples `sop`.
- R6: `port_en` holds its value for `payload_len` cycles, with a value of 0 treated as 1. The length is captured with `sop`. All enabled ports then drop on the same edge.
- R7: A packet that matches no entry leaves `port_en` at 0 and raises `no_match` for exactly one cycle, on the edge where `port_en` would have risen.
- R8: A write made while the engine is idle is used by the next packet.
- R9: A write made while a packet is being handled does not affect that packet. It is held, with a newer held write replacing an older one, and is applied in the first idle cycle before any later lookup.
- R10: `sop` is ignored while a packet is being handled.
- R11: A new `sop` is accepted in the first cycle after the enables of the previous packet have dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sop | input | 1 | Start-of-packet marker |
| din | input | 1 | Serial header bit |
| din_valid | input | 1 | `din` carries a header bit |
| payload_len | input | LEN_W | Payload length in cycles, captured with `sop` |
| wr_en | input | 1 | Table write strobe |
| wr_port | input | PW | Entry (output port) to write |
| wr_mask | input | 2^ADDR_W | Address mask for that entry |
| port_en | output | PORTS | Per-port switch enables |
| no_match | output | 1 | One-cycle pulse for a dropped packet |

## Verification
Every result of a packet is due at a fixed edge counted from the edge that samples `sop`. With N=4, the enables appear 21 edges later and stay for the clamped payload length. The unmatched flag appears on that same 21st edge for one cycle. The bench drives one input set per falling edge and records the outputs at every falling edge after each rising edge. It then compares the recorded rise edge, the enable value, the high-time and the flag position against those counts, and keeps sampling a few cycles beyond the expected end to catch late or extra activity. Held writes are checked by reading the result of the current packet, and then of the next one, at those same edges.

// File: rtl/ppm_route_pkg.sv
`timescale 1ns/1ps
package ppm_route_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAP,
    ST_CORR,
    ST_LAUNCH,
    ST_PAYLOAD
  } eng_state_t;

  // pulse-position frame: the single pulse sits where slot index equals the address
  function automatic logic slot_hit(input logic [31:0] addr, input logic [31:0] slot);
    return addr == slot;
  endfunction

endpackage

// File: rtl/hdr_deser.sv
`timescale 1ns/1ps
module hdr_deser #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic          din,
  output logic [AW-1:0] addr
);
  // LSB arrives first: shifting in from the top leaves it at bit 0 after AW shifts
  always_ff @(posedge clk) begin
    if (!rst_n)        addr <= '0;
    else if (clr)      addr <= '0;
    else if (shift_en) addr <= {din, addr[AW-1:1]};
  end
endmodule

// File: rtl/ppm_frame_gen.sv
`timescale 1ns/1ps
module ppm_frame_gen
  import ppm_route_pkg::*;
#(
  parameter int AW    = 4,
  parameter int SLOTS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] slot,
  output logic          pulse,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (!rst_n)    slot <= '0;
    else if (!run) slot <= '0;
    else           slot <= slot + 1'b1;
  end

  assign pulse = run && slot_hit(32'(addr), 32'(slot));
  assign last  = run && (slot == AW'(SLOTS - 1));
endmodule

// File: rtl/route_table.sv
`timescale 1ns/1ps
module route_table #(
  parameter int PORTS = 3,
  parameter int SLOTS = 16,
  parameter int PW    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [PW-1:0]               wport,
  input  logic [SLOTS-1:0]            wmask,
  output logic [PORTS-1:0][SLOTS-1:0] entries
);
  for (genvar p = 0; p < PORTS; p++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)                       entries[p] <= '0;
      else if (we && wport == PW'(p))   entries[p] <= wmask;
    end
  end
endmodule

// File: rtl/corr_unit.sv
`timescale 1ns/1ps
module corr_unit #(
  parameter int PORTS = 3,
  parameter int SLOTS = 16,
  parameter int AW    = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        pulse,
  input  logic [AW-1:0]               slot,
  input  logic [PORTS-1:0][SLOTS-1:0] entries,
  output logic [PORTS-1:0]            acc
);
  // one AND per entry per slot, latched until the next packet clears it
  for (genvar p = 0; p < PORTS; p++) begin : g_corr
    always_ff @(posedge clk) begin
      if (!rst_n)                          acc[p] <= 1'b0;
      else if (clear)                      acc[p] <= 1'b0;
      else if (pulse && entries[p][slot])  acc[p] <= 1'b1;
    end
  end
endmodule

// File: rtl/ppm_route_top.sv
`timescale 1ns/1ps
module ppm_route_top
  import ppm_route_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PORTS  = 3,
  parameter int LEN_W  = 8,
  localparam int SLOTS = 1 << ADDR_W,
  localparam int PW    = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sop,
  input  logic             din,
  input  logic             din_valid,
  input  logic [LEN_W-1:0] payload_len,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_port,
  input  logic [SLOTS-1:0] wr_mask,
  output logic [PORTS-1:0] port_en,
  output logic             no_match
);
  localparam int CW = $clog2(ADDR_W) + 1;

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction

  eng_state_t              state;
  logic [CW-1:0]           bitcnt;
  logic [LEN_W-1:0]        len_q, cnt;
  logic [PORTS-1:0]        port_en_q;
  logic                    nm_q;
  logic [ADDR_W-1:0]       hdr_addr;
  logic [ADDR_W-1:0]       slot;
  logic                    frame_pulse, frame_last;
  logic [PORTS-1:0]        corr_acc;
  logic [PORTS-1:0][SLOTS-1:0] entries;

  // held write
  logic                    pend_v;
  logic [PW-1:0]           pend_port;
  logic [SLOTS-1:0]        pend_mask;
  logic                    tbl_we;
  logic [PW-1:0]           tbl_port;
  logic [SLOTS-1:0]        tbl_mask;

  // named internal events
  logic busy, ev_sop_accept, ev_bit, ev_frame_done, ev_launch, ev_payload_end;
  assign busy           = (state != ST_IDLE);
  assign ev_sop_accept  = (state == ST_IDLE) && sop;
  assign ev_bit         = (state == ST_CAP) && din_valid;
  assign ev_frame_done  = (state == ST_CORR) && frame_last;
  assign ev_launch      = (state == ST_LAUNCH);
  assign ev_payload_end = (state == ST_PAYLOAD) && (cnt == LEN_W'(1));

  // table writes commit only while idle; a parked write goes first
  assign tbl_we   = !busy && (pend_v || wr_en);
  assign tbl_port = pend_v ? pend_port : wr_port;
  assign tbl_mask = pend_v ? pend_mask : wr_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_port <= '0;
      pend_mask <= '0;
    end else if (wr_en && (busy || pend_v)) begin
      pend_v    <= 1'b1;
      pend_port <= wr_port;
      pend_mask <= wr_mask;
    end else if (!busy) begin
      pend_v    <= 1'b0;
    end
  end

  hdr_deser #(.AW(ADDR_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr(ev_sop_accept), .shift_en(ev_bit),
    .din(din), .addr(hdr_addr)
  );

  ppm_frame_gen #(.AW(ADDR_W), .SLOTS(SLOTS)) u_frame (
    .clk(clk), .rst_n(rst_n), .run(state == ST_CORR), .addr(hdr_addr),
    .slot(slot), .pulse(frame_pulse), .last(frame_last)
  );

  route_table #(.PORTS(PORTS), .SLOTS(SLOTS), .PW(PW)) u_table (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .wport(tbl_port), .wmask(tbl_mask),
    .entries(entries)
  );

  corr_unit #(.PORTS(PORTS), .SLOTS(SLOTS), .AW(ADDR_W)) u_corr (
    .clk(clk), .rst_n(rst_n), .clear(ev_sop_accept), .pulse(frame_pulse),
    .slot(slot), .entries(entries), .acc(corr_acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      len_q     <= '0;
      cnt       <= '0;
      port_en_q <= '0;
      nm_q      <= 1'b0;
    end else begin
      nm_q <= 1'b0;
      case (state)
        ST_IDLE: if (sop) begin
          state  <= ST_CAP;
          bitcnt <= '0;
          len_q  <= clamp_len(payload_len);
        end
        ST_CAP: if (din_valid) begin
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == CW'(ADDR_W - 1)) state <= ST_CORR;
        end
        ST_CORR: if (frame_last) state <= ST_LAUNCH;
        ST_LAUNCH: begin
          if (|corr_acc) begin
            port_en_q <= corr_acc;
            cnt       <= len_q;
            state     <= ST_PAYLOAD;
          end else begin
            nm_q  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_PAYLOAD: begin
          if (cnt == LEN_W'(1)) begin
            port_en_q <= '0;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign port_en  = port_en_q;
  assign no_match = nm_q;
endmodule

// File: rtl/ppm_route_chk.sv
`timescale 1ns/1ps
module ppm_route_chk #(
  parameter int PORTS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PORTS-1:0] port_en,
  input logic             no_match,
  input logic [PORTS-1:0] acc,
  input logic             ev_launch,
  input logic             ev_frame_done,
  input logic             ev_payload_end,
  input logic             busy,
  input logic             wr_en,
  input logic             pend_v
);
  // R7
  no_match_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |=> !no_match);

  // R7
  no_match_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(no_match && (|port_en)));

  // R6
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|port_en) && !ev_payload_end) |=> (port_en == $past(port_en)));

  // R5
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|port_en) |-> ($past(ev_launch) && $past(ev_frame_done, 2)));

  // R3
  en_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|port_en) |-> ((port_en & ~acc) == '0));

  // R9
  write_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> pend_v);
endmodule

bind ppm_route_top ppm_route_chk #(.PORTS(PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .no_match(no_match),
  .acc(corr_acc), .ev_launch(ev_launch), .ev_frame_done(ev_frame_done),
  .ev_payload_end(ev_payload_end), .busy(busy), .wr_en(wr_en), .pend_v(pend_v)
);

// File: tb/sim_ppm_route_top.sv
`timescale 1ns/1ps
module sim_ppm_route_top;
  localparam int AW    = 4;
  localparam int PORTS = 3;
  localparam int LEN_W = 8;
  localparam int SLOTS = 1 << AW;
  localparam int LAT   = AW + SLOTS + 1;

  typedef struct packed {
    logic [3:0] a;
    logic [7:0] len;
    logic [2:0] exp;
  } vec_t;

  // address, payload length, expected enables (bit0 = port 1)
  localparam vec_t VEC [8] = '{
    '{4'd0,  8'd3, 3'b010},
    '{4'd1,  8'd1, 3'b001},
    '{4'd2,  8'd5, 3'b100},
    '{4'd7,  8'd2, 3'b001},
    '{4'd9,  8'd4, 3'b010},
    '{4'd11, 8'd0, 3'b100},
    '{4'd15, 8'd6, 3'b001},
    '{4'd8,  8'd3, 3'b100}
  };

  // output port (1-based) for addresses 0..15
  localparam int ROUTE [16] = '{2,1,3,1,3,2,2,1,3,2,2,3,1,1,2,1};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             sop = 1'b0, din = 1'b0, din_valid = 1'b0;
  logic [LEN_W-1:0] payload_len = '0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_port = '0;
  logic [SLOTS-1:0] wr_mask = '0;
  logic [PORTS-1:0] port_en;
  logic             no_match;

  int errors = 0;
  int checks = 0;
  logic [SLOTS-1:0] mask [PORTS];

  always #10 clk = ~clk;

  ppm_route_top #(.ADDR_W(AW), .PORTS(PORTS), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sop(sop), .din(din), .din_valid(din_valid),
    .payload_len(payload_len), .wr_en(wr_en), .wr_port(wr_port),
    .wr_mask(wr_mask), .port_en(port_en), .no_match(no_match)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic idle_write(input int p, input logic [SLOTS-1:0] m);
    wr_en = 1'b1; wr_port = 2'(p); wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // sop is sampled on the next rising edge (edge 0); outputs recorded after every edge
  task automatic run_pkt(input logic [3:0] a, input logic [7:0] len,
                         input logic [2:0] exp, input string req, input int tail,
                         input int wr_e, input int wp, input logic [SLOTS-1:0] wm,
                         input int sop2_e);
    int eff, tot, rise, width, nm_cnt, nm_at;
    logic [2:0] seen;
    bit same;
    eff = (len == 0) ? 1 : int'(len);
    tot = LAT + eff + tail;
    rise = -1; width = 0; nm_cnt = 0; nm_at = -1; seen = '0; same = 1'b1;
    sop = 1'b1; payload_len = len; din_valid = 1'b0;
    for (int k = 1; k <= tot + 1; k++) begin
      @(negedge clk);
      if (port_en != '0) begin
        if (rise < 0) begin rise = k - 1; seen = port_en; end
        else if (port_en != seen) same = 1'b0;
        width++;
      end
      if (no_match) begin nm_cnt++; if (nm_at < 0) nm_at = k - 1; end
      sop       = (k == sop2_e);
      din_valid = (k <= AW);
      din       = (k <= AW) ? a[k-1] : 1'b0;
      wr_en     = (k == wr_e);
      if (k == wr_e) begin wr_port = 2'(wp); wr_mask = wm; end
    end
    sop = 1'b0; din_valid = 1'b0; wr_en = 1'b0;
    if (exp != '0) begin
      chk(rise == LAT, req, "R5 enable rise edge", rise, LAT);
      chk(seen == exp, req, "R3 enable value", int'(seen), int'(exp));
      chk(width == eff, req, "R6 enable high cycles", width, eff);
      chk(same, req, "R6 enables drop together", int'(same), 1);
      chk(nm_cnt == 0, req, "R7 no flag on a match", nm_cnt, 0);
    end else begin
      chk(width == 0, req, "R7 enables stay low", width, 0);
      chk(nm_cnt == 1, req, "R7 flag one cycle", nm_cnt, 1);
      chk(nm_at == LAT, req, "R7 flag edge", nm_at, LAT);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int p = 0; p < PORTS; p++) mask[p] = '0;
    for (int i = 0; i < SLOTS; i++) mask[ROUTE[i] - 1][i] = 1'b1;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(port_en == '0, "R1", "enables in reset", int'(port_en), 0);
    chk(no_match == 1'b0, "R1", "flag in reset", int'(no_match), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(port_en == '0, "R1", "enables after reset", int'(port_en), 0);
    // R1 empty table drops the packet
    run_pkt(4'd5, 8'd2, 3'b000, "R1", 2, -1, 0, '0, -1);

    // R8 idle writes load the reference table
    for (int p = 0; p < PORTS; p++) idle_write(p, mask[p]);

    // R2 R3 R5 R6 vector walk
    foreach (VEC[i]) run_pkt(VEC[i].a, VEC[i].len, VEC[i].exp, "R2/R3", 2, -1, 0, '0, -1);

    // R4 multicast: address 6 also routed to port 1; R8 idle write used at once
    idle_write(0, mask[0] | 16'h0040);
    run_pkt(4'd6, 8'd3, 3'b011, "R4", 2, -1, 0, '0, -1);
    run_pkt(4'd6, 8'd1, 3'b011, "R8", 2, -1, 0, '0, -1);

    // R9 write during lookup: current packet unaffected, next packet sees it
    run_pkt(4'd2, 8'd2, 3'b100, "R9", 2, 6, 2, mask[2] & ~16'h0004, -1);
    run_pkt(4'd2, 8'd2, 3'b000, "R9", 2, -1, 0, '0, -1);
    // R9 newest held write wins
    run_pkt(4'd4, 8'd1, 3'b100, "R9", 2, 3, 2, 16'h0000, -1);
    run_pkt(4'd4, 8'd1, 3'b000, "R9", 2, 9, 2, mask[2], -1);
    run_pkt(4'd2, 8'd2, 3'b100, "R9", 2, -1, 0, '0, -1);

    // R10 sop during a lookup is ignored (long tail catches a stray launch)
    run_pkt(4'd9, 8'd2, 3'b010, "R10", 12, -1, 0, '0, 8);

    // R11 back to back: second sop in the first idle cycle
    run_pkt(4'd1, 8'd2, 3'b001, "R11", 0, -1, 0, '0, -1);
    run_pkt(4'd12, 8'd3, 3'b001, "R11", 2, -1, 0, '0, -1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule